// File: doc/BRIEF.md
# Wake Event Qualifier

This block watches a single asynchronous wake pin and decides whether activity on it is a real wake request. It emits a one-cycle qualified wake pulse only for activity that passes the selected test. It is meant to sit in the always-on domain of a sleeping node, ahead of whatever logic brings the rest of the node up.

The pin is first brought into the clock domain by a two-flop synchronizer. A run-time mode select then chooses one of three qualification styles. Edge style wants a debounced high pulse of at least a programmed width. Level style treats a debounced assert as a request and follows its deassert. Activity style counts transitions inside a programmed window and wakes once a programmed count is reached.

Events that pass debounce but fail the active test set a sticky rejection flag, which software clears with a one-cycle clear strobe. A fourth mode code disables qualification entirely.

Top module: `wake_qualifier`

## Requirements
- R1: The pin passes through two flops. The debounced level changes only after the synchronized value has differed from it on `cfg_debounce` consecutive clocks. A 0 or 1 means a single clock.
- R2: A high excursion of the pin held for fewer than `cfg_debounce` clocks changes nothing: no wake, no rejection, no level request.
- R3: In edge mode (`mode_sel` = 0), let the pin go high before edge e0, with debounce length N. If it stays high for at least `cfg_min_pulse` = M clocks, one `wake_pulse` is output in the cycle following edge e(N+1+M).
- R4: In edge mode, a pulse that passes debounce but whose debounced width is below `cfg_min_pulse` produces no wake and sets `rejected`.
- R5: `rejected` stays set until a cycle with `rej_clear` high clears it. If a new rejection and `rej_clear` fall in the same cycle, the flag stays set.
- R6: In level mode (`mode_sel` = 1), each debounced assert gives exactly one `wake_pulse`, one cycle after `level_req` rises. Holding the pin high gives no further pulses.
- R7: `level_req` is high exactly while level mode is selected and the debounced level is high. After the pin deasserts it drops, and the next assert wakes again.
- R8: In activity mode (`mode_sel` = 2), the first synchronized transition opens a window of `cfg_window` clocks, counting that clock as the first. A wake is output when the number of transitions in the window reaches `cfg_threshold`.
- R9: An activity window that ends without reaching the threshold discards its count and sets `rejected`. The next transition opens a fresh window.
- R10: Any change of `mode_sel` clears every counter and every partly qualified event, so qualification starts over.
- R11: With `mode_sel` = 3, no wake pulse and no level request are ever produced.
- R12: Synchronous active-high reset leaves `wake_pulse`, `level_req` and `rejected` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wake_raw | input | 1 | Asynchronous wake pin |
| mode_sel | input | 2 | 0 edge, 1 level, 2 activity, 3 disabled |
| cfg_debounce | input | DEB_W | Debounce length in clocks |
| cfg_min_pulse | input | CNT_W | Minimum debounced pulse width, edge mode |
| cfg_window | input | CNT_W | Activity window length in clocks |
| cfg_threshold | input | THR_W | Transitions needed inside a window |
| rej_clear | input | 1 | Clears the rejection flag |
| wake_pulse | output | 1 | Single-cycle qualified wake |
| level_req | output | 1 | Live level request in level mode |
| rejected | output | 1 | Sticky flag for events that failed qualification |

## Verification
The rejection path and the software clear can land in the same clock, and the flag must then stay set. The bench provokes this by timing `rej_clear` to the exact edge on which a too-short edge-mode pulse is judged. It then requires the flag to read high one cycle later, and low after a lone clear strobe. The same arithmetic timing model lets the edge and activity sweeps place pulses and transitions on both sides of every width, window and threshold boundary. The outcome of each placement is judged from the pulse count and the flag.

// File: rtl/wq_pkg.sv
package wq_pkg;
    typedef enum logic [1:0] {
        WQ_EDGE     = 2'd0,
        WQ_LEVEL    = 2'd1,
        WQ_ACTIVITY = 2'd2,
        WQ_OFF      = 2'd3
    } wq_mode_e;

    typedef struct packed {
        logic accept;
        logic short_ev;
    } wq_edge_res_t;

    typedef struct packed {
        logic hit;
        logic expire;
    } wq_act_res_t;
endpackage

// File: rtl/wq_sync.sv
module wq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] sh;

    always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= {sh[STAGES-2:0], din};
    end

    assign dout = sh[STAGES-1];
endmodule

// File: rtl/wq_debounce.sv
module wq_debounce #(
    parameter int DEB_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             din,
    input  logic [DEB_W-1:0] limit,
    output logic             lvl
);
    logic [DEB_W-1:0] cnt;
    logic [DEB_W:0]   nxt;
    logic             diff;

    assign diff = din != lvl;
    assign nxt  = {1'b0, cnt} + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            lvl <= 1'b0;
        end else if (clear) begin
            cnt <= '0;
        end else if (diff) begin
            if (nxt >= {1'b0, limit}) begin
                lvl <= din;
                cnt <= '0;
            end else begin
                cnt <= nxt[DEB_W-1:0];
            end
        end else begin
            cnt <= '0;
        end
    end

    // R1
    deb_follows_input_chk: assert property (@(posedge clk) disable iff (rst)
        (lvl != $past(lvl)) |-> ($past(din) == lvl));
endmodule

// File: rtl/wq_edge.sv
module wq_edge
    import wq_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             en,
    input  logic             deb,
    input  logic [CNT_W-1:0] min_len,
    output wq_edge_res_t     res
);
    logic [CNT_W-1:0] hi_cnt;
    logic             done;
    logic [CNT_W:0]   nxt;
    logic             reach;

    assign nxt   = {1'b0, hi_cnt} + 1'b1;
    assign reach = nxt >= {1'b0, min_len};

    always_ff @(posedge clk) begin
        if (rst || clear || !en) begin
            hi_cnt <= '0;
            done   <= 1'b0;
        end else if (deb) begin
            if (!done) begin
                if (reach) done   <= 1'b1;
                else       hi_cnt <= nxt[CNT_W-1:0];
            end
        end else begin
            hi_cnt <= '0;
            done   <= 1'b0;
        end
    end

    assign res.accept   = en && !clear && deb && !done && reach;
    assign res.short_ev = en && !clear && !deb && !done && (hi_cnt != '0);
endmodule

// File: rtl/wq_activity.sv
module wq_activity
    import wq_pkg::*;
#(
    parameter int CNT_W = 6,
    parameter int THR_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             en,
    input  logic             tog,
    input  logic [CNT_W-1:0] win_len,
    input  logic [THR_W-1:0] thresh,
    output wq_act_res_t      res
);
    logic [CNT_W-1:0] win_cnt;
    logic [THR_W-1:0] tog_cnt;
    logic [CNT_W:0]   n_win;
    logic [THR_W:0]   n_tog;
    logic             live;

    assign live  = (win_cnt != '0) || tog;
    assign n_win = {1'b0, win_cnt} + 1'b1;
    assign n_tog = {1'b0, tog_cnt} + {{THR_W{1'b0}}, tog};

    assign res.hit    = en && !clear && live && (n_tog >= {1'b0, thresh});
    assign res.expire = en && !clear && live && !res.hit && (n_win >= {1'b0, win_len});

    always_ff @(posedge clk) begin
        if (rst || clear || !en || res.hit || res.expire) begin
            win_cnt <= '0;
            tog_cnt <= '0;
        end else if (live) begin
            win_cnt <= n_win[CNT_W-1:0];
            tog_cnt <= n_tog[THR_W-1:0];
        end
    end
endmodule

// File: rtl/wake_qualifier.sv
module wake_qualifier
    import wq_pkg::*;
#(
    parameter int DEB_W       = 4,
    parameter int CNT_W       = 6,
    parameter int THR_W       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wake_raw,
    input  logic [1:0]       mode_sel,
    input  logic [DEB_W-1:0] cfg_debounce,
    input  logic [CNT_W-1:0] cfg_min_pulse,
    input  logic [CNT_W-1:0] cfg_window,
    input  logic [THR_W-1:0] cfg_threshold,
    input  logic             rej_clear,
    output logic             wake_pulse,
    output logic             level_req,
    output logic             rejected
);
    wq_mode_e     mode_q;
    wq_mode_e     mode_in;
    logic         mode_chg;
    logic         s_in;
    logic         s_prev;
    logic         tog;
    logic         deb;
    logic         lvl_seen;
    logic         wake_nxt;
    logic         reject_ev;
    wq_edge_res_t edge_r;
    wq_act_res_t  act_r;

    assign mode_in  = wq_mode_e'(mode_sel);
    assign mode_chg = mode_in != mode_q;
    assign tog      = s_in ^ s_prev;

    wq_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .din(wake_raw), .dout(s_in)
    );

    wq_debounce #(.DEB_W(DEB_W)) u_deb (
        .clk(clk), .rst(rst), .clear(mode_chg), .din(s_in),
        .limit(cfg_debounce), .lvl(deb)
    );

    wq_edge #(.CNT_W(CNT_W)) u_edge (
        .clk(clk), .rst(rst), .clear(mode_chg), .en(mode_q == WQ_EDGE),
        .deb(deb), .min_len(cfg_min_pulse), .res(edge_r)
    );

    wq_activity #(.CNT_W(CNT_W), .THR_W(THR_W)) u_act (
        .clk(clk), .rst(rst), .clear(mode_chg), .en(mode_q == WQ_ACTIVITY),
        .tog(tog), .win_len(cfg_window), .thresh(cfg_threshold), .res(act_r)
    );

    always_comb begin
        wake_nxt = 1'b0;
        if (!mode_chg) begin
            unique case (mode_q)
                WQ_EDGE:     wake_nxt = edge_r.accept;
                WQ_LEVEL:    wake_nxt = deb && !lvl_seen;
                WQ_ACTIVITY: wake_nxt = act_r.hit;
                default:     wake_nxt = 1'b0;
            endcase
        end
    end

    assign reject_ev = edge_r.short_ev || act_r.expire;
    assign level_req = (mode_q == WQ_LEVEL) && deb;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q     <= WQ_OFF;
            s_prev     <= 1'b0;
            lvl_seen   <= 1'b0;
            wake_pulse <= 1'b0;
            rejected   <= 1'b0;
        end else begin
            mode_q     <= mode_in;
            s_prev     <= s_in;
            wake_pulse <= wake_nxt;
            if (mode_chg || mode_q != WQ_LEVEL) lvl_seen <= 1'b0;
            else                                 lvl_seen <= deb;
            if (reject_ev)      rejected <= 1'b1;
            else if (rej_clear) rejected <= 1'b0;
        end
    end

    // R5
    rej_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (rejected && !rej_clear) |=> rejected);

    // R11
    off_no_wake_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_q == WQ_OFF) |-> !wake_pulse);

    // R3
    edge_needs_high_chk: assert property (@(posedge clk) disable iff (rst)
        (wake_pulse && mode_q == WQ_EDGE && $past(mode_q) == WQ_EDGE) |-> $past(deb));

    // R6
    level_wake_follows_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(level_req) && mode_sel == 2'd1) |=> wake_pulse);
endmodule

// File: tb/tb_wake_qualifier.sv
`timescale 1ns/1ps
module tb_wake_qualifier;
    localparam int DEB_W = 4;
    localparam int CNT_W = 6;
    localparam int THR_W = 4;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             wake_raw = 1'b0;
    logic [1:0]       mode_sel = 2'd3;
    logic [DEB_W-1:0] cfg_debounce = 4'd1;
    logic [CNT_W-1:0] cfg_min_pulse = 6'd1;
    logic [CNT_W-1:0] cfg_window = 6'd4;
    logic [THR_W-1:0] cfg_threshold = 4'd2;
    logic             rej_clear = 1'b0;
    logic             wake_pulse;
    logic             level_req;
    logic             rejected;

    int checks = 0;
    int errors = 0;
    int wake_seen = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    wake_qualifier #(.DEB_W(DEB_W), .CNT_W(CNT_W), .THR_W(THR_W)) dut (
        .clk(clk), .rst(rst), .wake_raw(wake_raw), .mode_sel(mode_sel),
        .cfg_debounce(cfg_debounce), .cfg_min_pulse(cfg_min_pulse),
        .cfg_window(cfg_window), .cfg_threshold(cfg_threshold),
        .rej_clear(rej_clear), .wake_pulse(wake_pulse),
        .level_req(level_req), .rejected(rejected)
    );

    always @(posedge clk) begin
        #2;
        if (wake_pulse) wake_seen++;
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear_flag();
        rej_clear = 1'b1;
        tick(1);
        rej_clear = 1'b0;
        tick(1);
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        tick(3);
        // R12 reset state
        chk(wake_pulse == 0 && level_req == 0 && rejected == 0, "R12", {wake_pulse, level_req, rejected}, 0);
        rst = 1'b0;
        tick(3);

        // Edge sweep: R2 (short glitches), R3 (wide), R4 (too narrow)
        mode_sel = 2'd0;
        tick(3);
        for (int n = 1; n <= 3; n++) begin
            for (int m = 1; m <= 5; m++) begin
                for (int l = 1; l <= 8; l++) begin
                    cfg_debounce = DEB_W'(n);
                    cfg_min_pulse = CNT_W'(m);
                    tick(2);
                    clear_flag();
                    wake_seen = 0;
                    wake_raw = 1'b1;
                    tick(l);
                    wake_raw = 1'b0;
                    tick(25);
                    if (l < n) begin
                        chk(wake_seen == 0, "R2 wake", wake_seen, 0);
                        chk(rejected == 0, "R2 rejected", rejected, 0);
                    end else if (l >= m) begin
                        chk(wake_seen == 1, "R3 wake", wake_seen, 1);
                        chk(rejected == 0, "R3 rejected", rejected, 0);
                    end else begin
                        chk(wake_seen == 0, "R4 wake", wake_seen, 0);
                        chk(rejected == 1, "R4 rejected", rejected, 1);
                    end
                end
            end
        end

        // R3 exact timing, N=2 M=3: pulse after edge e6
        cfg_debounce = 4'd2;
        cfg_min_pulse = 6'd3;
        tick(3);
        wake_raw = 1'b1;
        tick(6);
        chk(wake_pulse == 0, "R3 early", wake_pulse, 0);
        tick(1);
        chk(wake_pulse == 1, "R3 cycle", wake_pulse, 1);
        tick(1);
        chk(wake_pulse == 0, "R3 single", wake_pulse, 0);
        wake_raw = 1'b0;
        tick(20);

        // R5 collision: clear strobe on the judging edge of a short pulse
        cfg_debounce = 4'd1;
        cfg_min_pulse = 6'd5;
        clear_flag();
        wake_raw = 1'b1;
        tick(2);
        wake_raw = 1'b0;
        tick(3);
        rej_clear = 1'b1;
        tick(1);
        rej_clear = 1'b0;
        chk(rejected == 1, "R5 set wins", rejected, 1);
        tick(3);
        chk(rejected == 1, "R5 sticky", rejected, 1);
        rej_clear = 1'b1;
        tick(1);
        rej_clear = 1'b0;
        chk(rejected == 0, "R5 cleared", rejected, 0);

        // R10 edge: mode bounce restarts width count (N=1, M=6)
        cfg_debounce = 4'd1;
        cfg_min_pulse = 6'd6;
        tick(5);
        wake_seen = 0;
        wake_raw = 1'b1;
        tick(4);
        mode_sel = 2'd3;
        tick(1);
        mode_sel = 2'd0;
        tick(4);
        chk(wake_seen == 0, "R10 edge delayed", wake_seen, 0);
        tick(12);
        chk(wake_seen == 1, "R10 edge restarted", wake_seen, 1);
        wake_raw = 1'b0;
        tick(10);

        // Level mode: R6 and R7
        mode_sel = 2'd1;
        tick(3);
        for (int n = 1; n <= 4; n++) begin
            cfg_debounce = DEB_W'(n);
            tick(3);
            wake_seen = 0;
            wake_raw = 1'b1;
            tick(n + 2);
            chk(level_req == 1, "R7 req rises", level_req, 1);
            chk(wake_pulse == 0, "R6 not yet", wake_pulse, 0);
            tick(1);
            chk(wake_pulse == 1, "R6 pulse", wake_pulse, 1);
            tick(20);
            chk(wake_seen == 1, "R6 once", wake_seen, 1);
            wake_raw = 1'b0;
            tick(n + 5);
            chk(level_req == 0, "R7 deassert", level_req, 0);
            wake_raw = 1'b1;
            tick(n + 5);
            chk(wake_seen == 2, "R7 rearm", wake_seen, 2);
            wake_raw = 1'b0;
            tick(n + 5);
        end

        // Activity sweep: R8 and R9
        mode_sel = 2'd2;
        cfg_debounce = 4'd1;
        tick(3);
        for (int w = 3; w <= 8; w++) begin
            for (int t = 1; t <= 4; t++) begin
                for (int s = 1; s <= 3; s++) begin
                    cfg_window = CNT_W'(w);
                    cfg_threshold = THR_W'(t);
                    tick(3);
                    clear_flag();
                    wake_seen = 0;
                    for (int j = 0; j < t; j++) begin
                        wake_raw = ~wake_raw;
                        tick(s);
                    end
                    tick(w + 10);
                    if ((t - 1) * s + 1 <= w) begin
                        chk(wake_seen == 1, "R8 wake", wake_seen, 1);
                        chk(rejected == 0, "R8 rejected", rejected, 0);
                    end else begin
                        chk(wake_seen == 0, "R9 wake", wake_seen, 0);
                        chk(rejected == 1, "R9 rejected", rejected, 1);
                    end
                end
            end
        end

        // R10 activity: mode bounce discards partial count
        cfg_window = 6'd10;
        cfg_threshold = 4'd3;
        tick(3);
        wake_seen = 0;
        wake_raw = ~wake_raw;
        tick(1);
        wake_raw = ~wake_raw;
        tick(3);
        mode_sel = 2'd3;
        tick(1);
        mode_sel = 2'd2;
        tick(1);
        wake_raw = ~wake_raw;
        tick(30);
        chk(wake_seen == 0, "R10 activity cleared", wake_seen, 0);

        // R11 disabled mode
        mode_sel = 2'd3;
        cfg_threshold = 4'd1;
        tick(3);
        wake_seen = 0;
        for (int j = 0; j < 20; j++) begin
            wake_raw = ~wake_raw;
            tick(3);
        end
        wake_raw = 1'b1;
        tick(20);
        chk(wake_seen == 0, "R11 wake", wake_seen, 0);
        chk(level_req == 0, "R11 level_req", level_req, 0);

        finished = 1'b1;
        summary();
        $finish;
    end
endmodule